// File: doc/BRIEF.md
# Presence-Detect Serial Memory Slave

This block is a two-wire serial slave that holds a 256-byte presence-detect table in internal registers. A system clock much faster than the serial clock samples the SCL and SDA lines. Each line passes through a synchroniser, and START and STOP conditions are recognised from SDA transitions while SCL is high. The slave drives SDA only through an open-drain enable. It can pull the line low or release it, and nothing else. The board ties three strap inputs, which set the low bits of the seven-bit device address, so several of these slaves can share one bus.

A master can store bytes at a word address and can fetch bytes from the current pointer or from a word address it chooses. It can fetch any number of consecutive bytes. A write-protect input stops stores into the table. When a write ends, the slave models the nonvolatile programming time as a busy interval. During that interval it refuses its own address.

After reset the table holds values computed from two parameters. Byte 63 holds the 8-bit sum of bytes 0 to 62. Bytes 0 to 127 are meant for producer data and bytes 128 to 255 for the user, but the slave treats the two regions the same way.

Top module: `pd_eeprom_slave`

## Requirements
- R1: After reset the slave releases SDA (sda_oe low) and its internal pointer is 0.
- R2: The device address is the 7-bit value {DEV_TYPE (default 4'b1010), strap_i[2:0]}. It is sent MSB first, followed by a direction bit (1 = read, 0 = write). The slave acknowledges a matching address by pulling SDA low during the ninth clock. It does not acknowledge any other address, and it ignores the rest of that transfer up to the next START.
- R3: In a write transfer, the first byte after the address is loaded into the pointer. Every following byte is acknowledged and stored at the pointer, and the pointer then advances by one, wrapping from 255 to 0.
- R4: While wp_i is high, data bytes are still acknowledged, but the table is not changed and no busy interval follows.
- R5: After a STOP that ends a transfer in which at least one byte was stored, the slave is busy for PROG_CYCLES system clocks and does not acknowledge its address during that time.
- R6: Read data goes out MSB first, and SDA changes only while SCL is low. The pointer advances after each byte sent. An acknowledge from the master (SDA low in the ninth clock) continues the read. A not-acknowledge makes the slave release SDA and go idle.
- R7: A random read is a write transfer that carries only a word address, then a repeated START and a read. It returns the bytes starting at that word address.
- R8: A read with no word address before it starts at the pointer left by the previous access.
- R9: After reset, byte i holds (PRELOAD_BASE + i*PRELOAD_STEP) mod 256 for every i except 63. Byte 63 holds the sum mod 256 of bytes 0 to 62.
- R10: A START at any point, even in the middle of a byte, restarts address reception. A STOP releases SDA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin (wired-AND value) |
| sda_oe | output | 1 | High pulls SDA low; low releases the line |
| strap_i | input | 3 | Board straps forming the low three device-address bits |
| wp_i | input | 1 | Write protect, high blocks stores |

## Verification
The hardest condition to reach is the busy window. It opens only after a STOP that ends a transfer which really stored data. To observe it, the stimulus has to address the slave again within a few hundred serial bit times. The bench therefore issues an address probe straight after each unprotected write and expects a not-acknowledge. It then waits out the scaled-down interval and reads the data back. The same immediate probe after a protected write and after a write to a foreign address must be acknowledged, which shows that those transfers opened no window. A START in the middle of a byte is forced by clocking only four address bits before a repeated START.

// File: rtl/pd_pkg.sv
package pd_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_WADR,
      ST_WADR_ACK,
      ST_WDAT,
      ST_WDAT_ACK,
      ST_RDAT,
      ST_RACK
   } pd_state_e;

   localparam int unsigned PD_CSUM_IDX = 63;

   // Reset content of one table entry; the checksum entry sums all entries below it.
   function automatic logic [7:0] pd_seed_byte(input int unsigned idx,
                                               input logic [7:0] base,
                                               input logic [7:0] step);
      logic [7:0] acc;
      if (idx == PD_CSUM_IDX) begin
         acc = 8'h00;
         for (int unsigned k = 0; k < PD_CSUM_IDX; k++) begin
            acc = acc + base + 8'(k) * step;
         end
         return acc;
      end
      return base + 8'(idx) * step;
   endfunction

endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pd_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pd_sync: WIDTH must be at least 1");
   end

   // One flop chain per line; idle bus lines are high, so reset to 1.
   for (genvar b = 0; b < WIDTH; b++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], d_i[b]};
      end
      assign q_o[b] = chain[STAGES-1];
   end

endmodule

// File: rtl/pd_prog_timer.sv
module pd_prog_timer #(
   parameter int unsigned PROG_CYCLES = 1500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_i,
   output logic busy_o
);

   localparam int unsigned CW = $clog2(PROG_CYCLES + 1);

   if (PROG_CYCLES < 1) begin : g_bad_prog
      $error("pd_prog_timer: PROG_CYCLES must be at least 1");
   end

   logic [CW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               remain <= '0;
      else if (go_i)            remain <= CW'(PROG_CYCLES);
      else if (remain != '0)    remain <= remain - 1'b1;
   end

   assign busy_o = (remain != '0);

   // R5: a program request always opens a busy window on the next cycle
   assert_prog_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      go_i |=> busy_o);

endmodule

// File: rtl/pd_mem.sv
module pd_mem
   import pd_pkg::*;
#(
   parameter int unsigned DEPTH = 256,
   parameter int unsigned AW    = 8,
   parameter logic [7:0]  BASE  = 8'h21,
   parameter logic [7:0]  STEP  = 8'h0D
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic          wp_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [7:0]    wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [7:0]    rdata_o
);

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("pd_mem: DEPTH must equal 2**AW");
   end

   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            cells[i] <= pd_seed_byte(i, BASE, STEP);
         end
      end else if (we_i) begin
         cells[waddr_i] <= wdata_i;
      end
   end

   assign rdata_o = cells[raddr_i];

   // R4: the controller never issues a store while protection is active
   assert_wp_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |-> !wp_i);

endmodule

// File: rtl/pd_eeprom_slave.sv
module pd_eeprom_slave
   import pd_pkg::*;
#(
   parameter logic [3:0]  DEV_TYPE     = 4'b1010,
   parameter int unsigned DEPTH        = 256,
   parameter int unsigned PROG_CYCLES  = 1500000,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter logic [7:0]  PRELOAD_BASE = 8'h21,
   parameter logic [7:0]  PRELOAD_STEP = 8'h0D
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   input  logic [2:0] strap_i,
   input  logic       wp_i
);

   localparam int unsigned AW = $clog2(DEPTH);

   if (DEPTH < 64 || DEPTH > 256 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("pd_eeprom_slave: DEPTH must be a power of two from 64 to 256");
   end

   // ---------------- line sampling and bus conditions ----------------
   logic scl_s, sda_s, scl_q, sda_q;

   pd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({scl_i, sda_i}),
      .q_o   ({scl_s, sda_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   logic ev_rise, ev_fall, start_det, stop_det;
   assign ev_rise   = ~scl_q &  scl_s;
   assign ev_fall   =  scl_q & ~scl_s;
   assign start_det =  scl_q &  scl_s &  sda_q & ~sda_s;
   assign stop_det  =  scl_q &  scl_s & ~sda_q &  sda_s;

   // ---------------- protocol state ----------------
   pd_state_e     state;
   logic [7:0]    shreg;
   logic [7:0]    txreg;
   logic [3:0]    bitcnt;
   logic [AW-1:0] ptr;
   logic          is_read;
   logic          got_data;
   logic          mack_ok;
   logic          prog_go;
   logic          busy;
   logic          mem_we;
   logic [7:0]    mem_rdata;
   logic          byte_done;
   logic [6:0]    my_addr;

   assign byte_done = (bitcnt == 4'd8);
   assign my_addr   = {DEV_TYPE, strap_i};

   always_comb begin
      mem_we = ev_fall && (state == ST_WDAT) && byte_done && !wp_i;
   end

   pd_mem #(.DEPTH(DEPTH), .AW(AW), .BASE(PRELOAD_BASE), .STEP(PRELOAD_STEP)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (mem_we),
      .wp_i    (wp_i),
      .waddr_i (ptr),
      .wdata_i (shreg),
      .raddr_i (ptr),
      .rdata_o (mem_rdata)
   );

   pd_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (prog_go),
      .busy_o (busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         shreg    <= '0;
         txreg    <= '0;
         bitcnt   <= '0;
         ptr      <= '0;
         is_read  <= 1'b0;
         got_data <= 1'b0;
         mack_ok  <= 1'b0;
         prog_go  <= 1'b0;
         sda_oe   <= 1'b0;
      end else begin
         prog_go <= 1'b0;
         if (start_det) begin
            state  <= ST_DEV;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            state    <= ST_IDLE;
            sda_oe   <= 1'b0;
            prog_go  <= got_data;
            got_data <= 1'b0;
         end else if (ev_rise) begin
            case (state)
               ST_DEV, ST_WADR, ST_WDAT: begin
                  shreg  <= {shreg[6:0], sda_s};
                  bitcnt <= bitcnt + 1'b1;
               end
               ST_RDAT: bitcnt  <= bitcnt + 1'b1;
               ST_RACK: mack_ok <= ~sda_s;
               default: ;
            endcase
         end else if (ev_fall) begin
            case (state)
               ST_DEV: if (byte_done) begin
                  bitcnt <= '0;
                  if (shreg[7:1] == my_addr && !busy) begin
                     is_read <= shreg[0];
                     sda_oe  <= 1'b1;
                     state   <= ST_DEV_ACK;
                  end else begin
                     state   <= ST_IDLE;
                  end
               end
               ST_DEV_ACK: begin
                  if (is_read) begin
                     txreg  <= mem_rdata;
                     sda_oe <= ~mem_rdata[7];
                     state  <= ST_RDAT;
                  end else begin
                     sda_oe <= 1'b0;
                     state  <= ST_WADR;
                  end
               end
               ST_WADR: if (byte_done) begin
                  bitcnt <= '0;
                  ptr    <= shreg[AW-1:0];
                  sda_oe <= 1'b1;
                  state  <= ST_WADR_ACK;
               end
               ST_WDAT: if (byte_done) begin
                  bitcnt <= '0;
                  ptr    <= ptr + 1'b1;
                  if (!wp_i) got_data <= 1'b1;
                  sda_oe <= 1'b1;
                  state  <= ST_WDAT_ACK;
               end
               ST_WADR_ACK, ST_WDAT_ACK: begin
                  sda_oe <= 1'b0;
                  state  <= ST_WDAT;
               end
               ST_RDAT: begin
                  if (byte_done) begin
                     bitcnt <= '0;
                     ptr    <= ptr + 1'b1;
                     sda_oe <= 1'b0;
                     state  <= ST_RACK;
                  end else begin
                     txreg  <= {txreg[6:0], 1'b0};
                     sda_oe <= ~txreg[6];
                  end
               end
               ST_RACK: begin
                  if (mack_ok) begin
                     txreg  <= mem_rdata;
                     sda_oe <= ~mem_rdata[7];
                     state  <= ST_RDAT;
                  end else begin
                     sda_oe <= 1'b0;
                     state  <= ST_IDLE;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R5: the address is never acknowledged while the program window is open
   assert_no_ack_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DEV_ACK) |-> !busy);

   // R2: pulling SDA for the address phase only follows a matching address byte
   assert_ack_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_oe) && state == ST_DEV_ACK) |-> ($past(shreg[7:1]) == my_addr));

   // R6: while SCL stays high, the slave's drive does not move except at a bus condition
   assert_sda_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && scl_q && !start_det && !stop_det) |=> $stable(sda_oe));

   // R10: a STOP leaves the line released
   assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

endmodule

// File: tb/sim_pd_eeprom_slave.sv
module sim_pd_eeprom_slave;

   localparam int CLK_PERIOD = 10;
   localparam int PROG       = 1500;
   localparam int QTR        = 10;
   localparam logic [7:0] BASE  = 8'h21;
   localparam logic [7:0] STEP  = 8'h0D;
   localparam logic [2:0] STRAP = 3'b101;
   localparam logic [6:0] DEV   = {4'b1010, STRAP};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mscl = 1'b1;
   logic msda = 1'b1;
   logic wp = 1'b0;
   logic sda_oe;
   logic sda_line;

   assign sda_line = msda & ~sda_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   pd_eeprom_slave #(
      .PROG_CYCLES  (PROG),
      .PRELOAD_BASE (BASE),
      .PRELOAD_STEP (STEP)
   ) u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_i   (mscl),
      .sda_i   (sda_line),
      .sda_oe  (sda_oe),
      .strap_i (STRAP),
      .wp_i    (wp)
   );

   logic [7:0] model [256];
   logic [7:0] mptr;
   logic [7:0] wbuf [4];
   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   function automatic logic [7:0] ref_byte(input int i);
      logic [7:0] s;
      if (i != 63) return 8'((BASE + i * STEP) & 255);
      s = 8'h00;
      for (int j = 0; j < 63; j++) s = s + 8'((BASE + j * STEP) & 255);
      return s;
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_start();
      msda = 1'b1; tick(QTR);
      mscl = 1'b1; tick(2*QTR);
      msda = 1'b0; tick(2*QTR);
      mscl = 1'b0; tick(QTR);
   endtask

   task automatic bus_stop();
      msda = 1'b0; tick(QTR);
      mscl = 1'b1; tick(2*QTR);
      msda = 1'b1; tick(2*QTR);
   endtask

   task automatic wbit(input logic b);
      msda = b;    tick(QTR);
      mscl = 1'b1; tick(2*QTR);
      mscl = 1'b0; tick(QTR);
   endtask

   task automatic rbit(output logic b);
      msda = 1'b1; tick(QTR);
      mscl = 1'b1; tick(QTR);
      b = sda_line; tick(QTR);
      mscl = 1'b0; tick(QTR);
   endtask

   task automatic wbyte(input logic [7:0] v, output bit ack);
      logic b;
      for (int i = 7; i >= 0; i--) wbit(v[i]);
      rbit(b);
      ack = ~b;
   endtask

   task automatic rbyte(input bit last, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         rbit(b);
         v[i] = b;
      end
      wbit(last);
   endtask

   task automatic do_write(input logic [7:0] a, input int n, input string tag);
      bit ack;
      bus_start();
      wbyte({DEV, 1'b0}, ack); chk(ack, tag, ack, 1);
      wbyte(a, ack);           chk(ack, tag, ack, 1);
      for (int i = 0; i < n; i++) begin
         logic [7:0] x;
         x = a + 8'(i);
         wbyte(wbuf[i], ack);  chk(ack, tag, ack, 1);
         if (!wp) model[x] = wbuf[i];
      end
      bus_stop();
      mptr = a + 8'(n);
   endtask

   task automatic do_rand_read(input logic [7:0] a, input int n, input string tag);
      bit ack;
      logic [7:0] v;
      bus_start();
      wbyte({DEV, 1'b0}, ack); chk(ack, tag, ack, 1);
      wbyte(a, ack);           chk(ack, tag, ack, 1);
      bus_start();
      wbyte({DEV, 1'b1}, ack); chk(ack, tag, ack, 1);
      for (int i = 0; i < n; i++) begin
         logic [7:0] x;
         x = a + 8'(i);
         rbyte(i == n - 1, v);
         chk(v == model[x], tag, v, model[x]);
      end
      chk(sda_oe == 1'b0, {tag, " R6 release after NACK"}, sda_oe, 0);
      bus_stop();
      mptr = a + 8'(n);
   endtask

   task automatic probe_busy(input bit expect_ack, input string tag);
      bit ack;
      bus_start();
      wbyte({DEV, 1'b0}, ack);
      chk(ack == expect_ack, tag, ack, expect_ack);
      bus_stop();
   endtask

   initial begin
      bit ack;
      logic [7:0] v;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 256; i++) model[i] = ref_byte(i);
      mptr = 8'h00;
      tick(5);
      // R1: released line out of reset
      chk(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);
      rst_n = 1'b1;
      tick(20);
      chk(sda_oe == 1'b0, "R1 idle release", sda_oe, 0);

      // R1/R8: a current-address read straight after reset starts at byte 0
      bus_start();
      wbyte({DEV, 1'b1}, ack); chk(ack, "R8 addr ack", ack, 1);
      rbyte(1'b1, v);          chk(v == model[0], "R1 R8 pointer zero", v, model[0]);
      bus_stop();
      mptr = 8'h01;

      // R9, R7, R6: sequential random read over the first 64 bytes incl. checksum
      do_rand_read(8'h00, 64, "R9 R7 R6 preload");

      // R8: continue from the pointer the sequential read left
      bus_start();
      wbyte({DEV, 1'b1}, ack); chk(ack, "R8 addr ack", ack, 1);
      rbyte(1'b1, v);          chk(v == model[mptr], "R8 current read", v, model[mptr]);
      bus_stop();
      mptr = mptr + 8'd1;

      // R3 and R5: write across the top of the table, then probe while busy
      wbuf[0] = 8'hA5; wbuf[1] = 8'h5A; wbuf[2] = 8'hC3;
      do_write(8'hFE, 3, "R3 wrap write");
      probe_busy(1'b0, "R5 nack while busy");
      tick(PROG + 100);
      probe_busy(1'b1, "R5 ack after window");
      do_rand_read(8'hFE, 3, "R3 wrap readback");

      // R4: protected write is acknowledged, changes nothing, opens no window
      wp = 1'b1;
      wbuf[0] = 8'h11; wbuf[1] = 8'h22;
      do_write(8'd130, 2, "R4 protected write");
      wp = 1'b0;
      probe_busy(1'b1, "R4 no window");
      do_rand_read(8'd130, 2, "R4 unchanged");

      // R2: foreign address is ignored for the whole transfer
      bus_start();
      wbyte({DEV ^ 7'h01, 1'b0}, ack); chk(!ack, "R2 foreign nack", ack, 0);
      wbyte(8'h10, ack);               chk(!ack, "R2 word ignored", ack, 0);
      wbyte(8'hEE, ack);               chk(!ack, "R2 data ignored", ack, 0);
      bus_stop();
      probe_busy(1'b1, "R2 no window");
      do_rand_read(8'h10, 1, "R2 unchanged");

      // R10: START in the middle of an address byte restarts reception
      bus_start();
      for (int i = 6; i >= 3; i--) wbit(DEV[i]);
      bus_start();
      wbyte({DEV, 1'b1}, ack); chk(ack, "R10 restart ack", ack, 1);
      rbyte(1'b1, v);          chk(v == model[mptr], "R10 restart read", v, model[mptr]);
      bus_stop();
      mptr = mptr + 8'd1;
      chk(sda_oe == 1'b0, "R10 stop release", sda_oe, 0);

      // Random writes and readbacks
      for (int it = 0; it < 12; it++) begin
         logic [7:0] a;
         int n;
         a = 8'($urandom);
         n = 1 + int'($urandom % 3);
         for (int k = 0; k < 4; k++) wbuf[k] = 8'($urandom);
         do_write(a, n, "R3 random write");
         probe_busy(1'b0, "R5 random busy");
         tick(PROG + 100);
         do_rand_read(a, n, "R7 random readback");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

endmodule